// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the command pins of a graphics-class synchronous DRAM on every rising clock edge and turns them into a decoded command. The pins it samples are chip select, row strobe, column strobe, write enable, clock enable, a 3-bit bank field and a 12-bit address. Alongside the decoded command it presents the target bank, the row or column address and the auto-precharge and precharge-all flags. It also raises a flag when a command is not legal in the current bank state. All of these outputs are registered, so they appear just after the edge that sampled the pins.

Internally it keeps one small state machine per bank, each with the states IDLE, OPEN and AP_WAIT, and records the row held by each open bank. A global power state machine has the states RUN, PDN_PRE (precharge power-down) and PDN_ACT (active power-down). A mode register captures the read latency, the write latency and the burst length from the address bus. These values set how many clocks a bank stays open after a read or write that requested auto-precharge.

The bank transitions are:
- IDLE to OPEN on an activate.
- OPEN to IDLE on a precharge.
- OPEN to AP_WAIT on a read or write with auto-precharge.
- AP_WAIT to IDLE when its countdown expires or on a precharge.

The power transitions are:
- RUN to PDN_PRE when clock enable is sampled low with every bank idle.
- RUN to PDN_ACT when clock enable is sampled low with any bank not idle.
- PDN_PRE or PDN_ACT to RUN when clock enable is sampled high.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset the block reports the following:
  - `cmd_o` = 0;
  - every bank idle, with all open rows zero;
  - `pwr_o` = 0;
  - read latency 7, write latency 1, burst of four (`burst8_o` = 0);
  - every other output zero.
- R2: Pin decoding, with codes given as (ras_n,cas_n,we_n) and chip select low:
  - chip select high reports DESEL and changes no state;
  - 111 → NOP=1, 011 → ACT=2, 101 → READ=3, 100 → WRITE=4, 010 → PRE=5, 001 → REF=6, 000 → MRS=7, 110 → RSVD=8;
  - `cmd_o` shows the code from the edge after sampling;
  - `bank_o` shows the bank field for every command except DESEL and NOP, and is 0 otherwise.
- R3: ACT to an idle bank opens it. The bank's slice of `open_row_o` (bits b*12+11..b*12) then holds address bits 11..0, and `row_o` shows that address for the ACT cycle.
- R4: READ and WRITE report `col_o` = {A9, A7..A0} and `auto_pre_o` = A8. A READ or WRITE without A8 leaves the bank open.
- R5: PRE with A8 low closes only the selected bank. PRE with A8 high closes all banks. `pre_all_o` shows A8. PRE to an idle bank is legal, and PRE cancels a pending auto-precharge.
- R6: A READ or WRITE with A8 high sends the bank to AP_WAIT. The bank stays reported open and closes exactly D edges after the command edge:
  - for a READ, D = read latency + 2 (burst of four) or + 4 (burst of eight);
  - for a WRITE, the write latency replaces the read latency.
- R7: The following raise `illegal_o` for one cycle and change no bank state:
  - READ or WRITE to a bank that is not OPEN (including AP_WAIT);
  - ACT to a bank that is not idle;
  - the RSVD code;
  - REF while any bank is not idle.
- R8: MRS with bank field 0 is accepted only when all banks are idle. It latches the following fields:
  - A0 sets the burst of eight;
  - A3..A1 hold a code n, giving read latency 7+n;
  - A6..A4 hold a code m, giving write latency 1+m.
  A code of 7 in either latency field is illegal. MRS with a nonzero bank field is accepted without changing the fields. MRS with any bank not idle is illegal.
- R9: In RUN, clock enable sampled low enters PDN_PRE (`pwr_o`=1) if all banks are idle, and PDN_ACT (`pwr_o`=2) otherwise. The command on that edge is ignored and reported as DESEL.
- R10: In either power-down state, commands are ignored (reported as DESEL, with no state change). Clock enable sampled high returns to RUN (`pwr_o`=0), and the command on that edge is also ignored. Auto-precharge countdowns keep running during power-down.
- R11: REF with all banks idle is accepted, is not flagged, and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 3 | Bank field |
| addr_i | input | 12 | Address bus |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 3 | Target bank |
| row_o | output | 12 | Row address of an ACT |
| col_o | output | 9 | Column address of a READ/WRITE |
| auto_pre_o | output | 1 | Auto-precharge requested |
| pre_all_o | output | 1 | Precharge of all banks |
| illegal_o | output | 1 | Command illegal in current state |
| bank_open_o | output | 8 | Per-bank open status |
| open_row_o | output | 96 | Open row per bank, 12 bits each |
| pwr_o | output | 2 | Power state: 0 RUN, 1 PDN_PRE, 2 PDN_ACT |
| cas_lat_o | output | 5 | Current read latency |
| wr_lat_o | output | 5 | Current write latency |
| burst8_o | output | 1 | Burst of eight selected |

## Verification
The assertions assume that the pins carry known values from the first edge after reset. They also assume that reset is held across at least one rising edge, so that every history they compare against starts from the reset state. The stimulus changes pins only on falling edges and holds reset for three edges. It moves clock enable only through the entry and exit sequences described above. Because of this, every bank opening seen at the outputs can be traced to an accepted activate, and every power-down period is framed by a clock-enable change.

// File: rtl/cmdtrk_pkg.sv
package cmdtrk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_READ  = 4'd3,
        CMD_WRITE = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_REF   = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_RSVD  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN     = 2'd0,
        PWR_PDN_PRE = 2'd1,
        PWR_PDN_ACT = 2'd2
    } pwr_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_OPEN   = 2'd1,
        BK_APWAIT = 2'd2
    } bank_e;

endpackage

// File: rtl/cmdtrk_decode.sv
module cmdtrk_decode
    import cmdtrk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_RSVD;
            endcase
        end
    end

endmodule

// File: rtl/cmdtrk_mode.sv
module cmdtrk_mode #(
    parameter int LAT_W   = 5,
    parameter int CL_BASE = 7,
    parameter int WL_BASE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [6:0]       field,
    output logic             field_ok,
    output logic [LAT_W-1:0] cas_lat,
    output logic [LAT_W-1:0] wr_lat,
    output logic             burst8
);

    logic [2:0] cl_code_q;
    logic [2:0] wl_code_q;
    logic       bl8_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_code_q <= 3'd0;
            wl_code_q <= 3'd0;
            bl8_q     <= 1'b0;
        end else if (load) begin
            bl8_q     <= field[0];
            cl_code_q <= field[3:1];
            wl_code_q <= field[6:4];
        end
    end

    always_comb begin
        field_ok = (field[3:1] != 3'd7) && (field[6:4] != 3'd7);
        cas_lat  = LAT_W'(CL_BASE) + LAT_W'(cl_code_q);
        wr_lat   = LAT_W'(WL_BASE) + LAT_W'(wl_code_q);
        burst8   = bl8_q;
    end

endmodule

// File: rtl/cmdtrk_bank.sv
module cmdtrk_bank
    import cmdtrk_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             rwap_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    input  logic [LAT_W-1:0] delay_in,
    output bank_e            state_o,
    output logic [ROW_W-1:0] row_o
);

    bank_e            state_q, state_d;
    logic [LAT_W-1:0] cnt_q, cnt_d;
    logic [ROW_W-1:0] row_q, row_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            row_q   <= row_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        row_d   = row_q;
        unique case (state_q)
            BK_IDLE: begin
                if (open_req) begin
                    state_d = BK_OPEN;
                    row_d   = row_in;
                end
            end
            BK_OPEN: begin
                if (close_req) begin
                    state_d = BK_IDLE;
                end else if (rwap_req) begin
                    state_d = BK_APWAIT;
                    cnt_d   = delay_in;
                end
            end
            BK_APWAIT: begin
                if (close_req || cnt_q == LAT_W'(1)) begin
                    state_d = BK_IDLE;
                end else begin
                    cnt_d = cnt_q - LAT_W'(1);
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    always_comb begin
        state_o = state_q;
        row_o   = (state_q == BK_IDLE) ? '0 : row_q;
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import cmdtrk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 8,
    parameter int CL_BASE   = 7,
    parameter int WL_BASE   = 1,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int LAT_W    = $clog2(CL_BASE + 7 + 4 + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke_i,
    input  logic                       cs_n_i,
    input  logic                       ras_n_i,
    input  logic                       cas_n_i,
    input  logic                       we_n_i,
    input  logic [BANK_W-1:0]          ba_i,
    input  logic [ROW_W-1:0]           addr_i,
    output logic [3:0]                 cmd_o,
    output logic [BANK_W-1:0]          bank_o,
    output logic [ROW_W-1:0]           row_o,
    output logic [COL_W-1:0]           col_o,
    output logic                       auto_pre_o,
    output logic                       pre_all_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
    output logic [1:0]                 pwr_o,
    output logic [LAT_W-1:0]           cas_lat_o,
    output logic [LAT_W-1:0]           wr_lat_o,
    output logic                       burst8_o
);

    cmd_e                 raw_cmd;
    pwr_e                 pwr_q, pwr_d;
    bank_e                bk_state [NUM_BANKS];
    logic [ROW_W-1:0]     bk_row   [NUM_BANKS];
    logic [NUM_BANKS-1:0] bk_busy;
    logic [NUM_BANKS-1:0] open_req, rwap_req, close_req;
    logic                 any_busy, run_cyc, illegal, mode_load, field_ok;
    logic [LAT_W-1:0]     cas_lat, wr_lat, ap_delay;
    logic                 burst8;

    cmd_e                 cmd_q;
    logic [BANK_W-1:0]    bank_q;
    logic [ROW_W-1:0]     row_q;
    logic [COL_W-1:0]     col_q;
    logic                 ap_q, pa_q, ill_q;

    cmdtrk_decode u_decode (
        .cs_n  (cs_n_i),
        .ras_n (ras_n_i),
        .cas_n (cas_n_i),
        .we_n  (we_n_i),
        .cmd   (raw_cmd)
    );

    cmdtrk_mode #(
        .LAT_W   (LAT_W),
        .CL_BASE (CL_BASE),
        .WL_BASE (WL_BASE)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode_load),
        .field    (addr_i[6:0]),
        .field_ok (field_ok),
        .cas_lat  (cas_lat),
        .wr_lat   (wr_lat),
        .burst8   (burst8)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        cmdtrk_bank #(
            .ROW_W (ROW_W),
            .LAT_W (LAT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[b]),
            .rwap_req  (rwap_req[b]),
            .close_req (close_req[b]),
            .row_in    (addr_i),
            .delay_in  (ap_delay),
            .state_o   (bk_state[b]),
            .row_o     (bk_row[b])
        );
        assign bk_busy[b]                      = (bk_state[b] != BK_IDLE);
        assign open_row_o[b*ROW_W +: ROW_W]    = bk_row[b];
    end

    assign any_busy = |bk_busy;
    assign run_cyc  = (pwr_q == PWR_RUN) && cke_i;
    assign ap_delay = ((raw_cmd == CMD_READ) ? cas_lat : wr_lat)
                    + (burst8 ? LAT_W'(4) : LAT_W'(2));

    // Command legality and per-bank requests
    always_comb begin
        logic [NUM_BANKS-1:0] sel;
        for (int b = 0; b < NUM_BANKS; b++) begin
            sel[b] = (ba_i == BANK_W'(b));
        end
        illegal   = 1'b0;
        mode_load = 1'b0;
        open_req  = '0;
        rwap_req  = '0;
        close_req = '0;
        if (run_cyc) begin
            unique case (raw_cmd)
                CMD_ACT: begin
                    if (bk_state[ba_i] != BK_IDLE) illegal = 1'b1;
                    else                           open_req = sel;
                end
                CMD_READ, CMD_WRITE: begin
                    if (bk_state[ba_i] != BK_OPEN) illegal = 1'b1;
                    else if (addr_i[AP_BIT])       rwap_req = sel;
                end
                CMD_PRE: begin
                    close_req = addr_i[AP_BIT] ? '1 : sel;
                end
                CMD_REF: begin
                    illegal = any_busy;
                end
                CMD_MRS: begin
                    if (any_busy || (ba_i == '0 && !field_ok)) illegal = 1'b1;
                    else                                       mode_load = (ba_i == '0);
                end
                CMD_RSVD: illegal = 1'b1;
                default: ;
            endcase
        end
    end

    // Power state register
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= PWR_RUN;
        else        pwr_q <= pwr_d;
    end

    // Power state transitions
    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PWR_RUN:     if (!cke_i) pwr_d = any_busy ? PWR_PDN_ACT : PWR_PDN_PRE;
            PWR_PDN_PRE: if (cke_i)  pwr_d = PWR_RUN;
            PWR_PDN_ACT: if (cke_i)  pwr_d = PWR_RUN;
            default:     pwr_d = PWR_RUN;
        endcase
    end

    // Registered command report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_DESEL;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            ap_q   <= 1'b0;
            pa_q   <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            cmd_q  <= run_cyc ? raw_cmd : CMD_DESEL;
            bank_q <= (run_cyc && raw_cmd != CMD_DESEL && raw_cmd != CMD_NOP) ? ba_i : '0;
            row_q  <= (run_cyc && raw_cmd == CMD_ACT) ? addr_i : '0;
            if (run_cyc && (raw_cmd == CMD_READ || raw_cmd == CMD_WRITE)) begin
                col_q <= {addr_i[COL_W:AP_BIT+1], addr_i[AP_BIT-1:0]};
                ap_q  <= addr_i[AP_BIT];
            end else begin
                col_q <= '0;
                ap_q  <= 1'b0;
            end
            pa_q   <= run_cyc && raw_cmd == CMD_PRE && addr_i[AP_BIT];
            ill_q  <= illegal;
        end
    end

    assign cmd_o       = cmd_q;
    assign bank_o      = bank_q;
    assign row_o       = row_q;
    assign col_o       = col_q;
    assign auto_pre_o  = ap_q;
    assign pre_all_o   = pa_q;
    assign illegal_o   = ill_q;
    assign bank_open_o = bk_busy;
    assign pwr_o       = pwr_q;
    assign cas_lat_o   = cas_lat;
    assign wr_lat_o    = wr_lat;
    assign burst8_o    = burst8;

endmodule

// File: rtl/cmdtrk_chk.sv
module cmdtrk_chk
    import cmdtrk_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           cmd_o,
    input logic                 illegal_o,
    input logic [NUM_BANKS-1:0] bank_open_o,
    input logic [1:0]           pwr_o
);

    // R3
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_open_o & ~$past(bank_open_o)) != '0) |-> (cmd_o == CMD_ACT && !illegal_o));

    // R7
    illegal_no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ((bank_open_o & ~$past(bank_open_o)) == '0));

    // R8
    mrs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_MRS && $past(bank_open_o) != '0) |-> illegal_o);

    // R9
    pdn_pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o == PWR_PDN_PRE && $past(pwr_o) == PWR_RUN) |-> ($past(bank_open_o) == '0));

    // R10
    pdn_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o != PWR_RUN) |-> (cmd_o == CMD_DESEL && !illegal_o));

    // R2
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_DESEL) |-> ((bank_open_o & ~$past(bank_open_o)) == '0));

endmodule

bind sdram_cmd_tracker cmdtrk_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .illegal_o   (illegal_o),
    .bank_open_o (bank_open_o),
    .pwr_o       (pwr_o)
);

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [11:0] addr;
    logic [3:0]  cmd_o;
    logic [2:0]  bank_o;
    logic [11:0] row_o;
    logic [8:0]  col_o;
    logic        auto_pre_o, pre_all_o, illegal_o, burst8_o;
    logic [7:0]  bank_open_o;
    logic [95:0] open_row_o;
    logic [1:0]  pwr_o;
    logic [4:0]  cas_lat_o, wr_lat_o;

    always #4 clk = ~clk;

    sdram_cmd_tracker i_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
        .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o), .illegal_o(illegal_o),
        .bank_open_o(bank_open_o), .open_row_o(open_row_o), .pwr_o(pwr_o),
        .cas_lat_o(cas_lat_o), .wr_lat_o(wr_lat_o), .burst8_o(burst8_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_st[8];
    int m_row[8];
    int m_cnt[8];
    int m_cl = 7, m_wl = 1, m_bl8 = 0, m_pwr = 0;
    int e_cmd, e_bank, e_row, e_col, e_ap, e_pa, e_ill;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model(input logic k, input logic cs, input logic r, input logic c,
                         input logic w, input logic [2:0] b, input logic [11:0] a);
        int  code;
        bit  busy;
        bit  acc;
        int  pre_st[8];
        busy = 0;
        for (int i = 0; i < 8; i++) begin
            pre_st[i] = m_st[i];
            if (m_st[i] != 0) busy = 1;
        end
        e_cmd = 0; e_bank = 0; e_row = 0; e_col = 0; e_ap = 0; e_pa = 0; e_ill = 0;
        if (cs) code = 0;
        else case ({r, c, w})
            3'b111: code = 1;
            3'b011: code = 2;
            3'b101: code = 3;
            3'b100: code = 4;
            3'b010: code = 5;
            3'b001: code = 6;
            3'b000: code = 7;
            default: code = 8;
        endcase
        acc = (m_pwr == 0) && k;
        if (acc) begin
            e_cmd = code;
            if (code >= 2) e_bank = int'(b);
            case (code)
                2: begin e_row = int'(a); e_ill = (pre_st[b] != 0); end
                3, 4: begin
                    e_col = int'({a[9], a[7:0]});
                    e_ap  = int'(a[8]);
                    e_ill = (pre_st[b] != 1);
                end
                5: e_pa = int'(a[8]);
                6: e_ill = busy;
                7: e_ill = busy || (b == 0 && (a[3:1] == 3'd7 || a[6:4] == 3'd7));
                8: e_ill = 1;
                default: ;
            endcase
        end
        for (int i = 0; i < 8; i++) begin
            if (m_st[i] == 2) begin
                if (m_cnt[i] == 1) m_st[i] = 0;
                else m_cnt[i]--;
            end
        end
        if (acc && !e_ill) begin
            case (code)
                2: begin m_st[b] = 1; m_row[b] = int'(a); end
                3, 4: if (a[8]) begin
                    m_st[b]  = 2;
                    m_cnt[b] = ((code == 3) ? m_cl : m_wl) + (m_bl8 ? 4 : 2);
                end
                5: begin
                    if (a[8]) for (int i = 0; i < 8; i++) m_st[i] = 0;
                    else m_st[b] = 0;
                end
                7: if (b == 0) begin
                    m_bl8 = int'(a[0]);
                    m_cl  = 7 + int'(a[3:1]);
                    m_wl  = 1 + int'(a[6:4]);
                end
                default: ;
            endcase
        end
        if (m_pwr == 0) begin
            if (!k) m_pwr = busy ? 2 : 1;
        end else if (k) begin
            m_pwr = 0;
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "R2 cmd_o", 32'(cmd_o), 32'(e_cmd));
        check(tag, "R2 bank_o", 32'(bank_o), 32'(e_bank));
        check(tag, "R3 row_o", 32'(row_o), 32'(e_row));
        check(tag, "R4 col_o", 32'(col_o), 32'(e_col));
        check(tag, "R4 auto_pre_o", 32'(auto_pre_o), 32'(e_ap));
        check(tag, "R5 pre_all_o", 32'(pre_all_o), 32'(e_pa));
        check(tag, "R7 illegal_o", 32'(illegal_o), 32'(e_ill));
        check(tag, "R9 pwr_o", 32'(pwr_o), 32'(m_pwr));
        check(tag, "R8 cas_lat_o", 32'(cas_lat_o), 32'(m_cl));
        check(tag, "R8 wr_lat_o", 32'(wr_lat_o), 32'(m_wl));
        check(tag, "R8 burst8_o", 32'(burst8_o), 32'(m_bl8));
        for (int i = 0; i < 8; i++) begin
            check(tag, "R6 bank_open_o", 32'(bank_open_o[i]), 32'(m_st[i] != 0));
            check(tag, "R3 open_row_o", 32'(open_row_o[i*12 +: 12]),
                  32'((m_st[i] != 0) ? m_row[i] : 0));
        end
    endtask

    task automatic cyc(string tag, input logic k, input logic cs, input logic r,
                       input logic c, input logic w, input logic [2:0] b,
                       input logic [11:0] a);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
        @(posedge clk);
        model(k, cs, r, c, w, b, a);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic nop(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 1, 0, 1, 1, 1, 3'd0, 12'h000);
    endtask
    task automatic act(string tag, logic [2:0] b, logic [11:0] row);
        cyc(tag, 1, 0, 0, 1, 1, b, row);
    endtask
    task automatic rd(string tag, logic [2:0] b, logic [11:0] a);
        cyc(tag, 1, 0, 1, 0, 1, b, a);
    endtask
    task automatic wr(string tag, logic [2:0] b, logic [11:0] a);
        cyc(tag, 1, 0, 1, 0, 0, b, a);
    endtask
    task automatic pre(string tag, logic [2:0] b, logic all);
        cyc(tag, 1, 0, 0, 1, 0, b, {3'b000, all, 8'h00});
    endtask
    task automatic mrs(string tag, logic [2:0] b, logic [11:0] a);
        cyc(tag, 1, 0, 0, 0, 0, b, a);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_row[i] = 0; m_cnt[i] = 0; end
        rst_n = 0; cke = 1; cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_cmd = 0; e_bank = 0; e_row = 0; e_col = 0; e_ap = 0; e_pa = 0; e_ill = 0;
        compare_all("R1 reset");
        rst_n = 1;

        nop("R2 nop", 2);
        cyc("R2 cs high masks act", 1, 1, 0, 1, 1, 3'd3, 12'h555);
        act("R3 act bank3", 3'd3, 12'hABC);
        act("R3 act bank0", 3'd0, 12'h123);
        act("R7 act open bank", 3'd3, 12'h111);
        rd("R4 read no ap", 3'd3, 12'h2A5);
        wr("R4 write no ap", 3'd0, 12'h05A);
        wr("R6 write ap bank0", 3'd0, 12'h1FF);
        wr("R7 write during ap wait", 3'd0, 12'h001);
        nop("R6 ap countdown", 4);
        rd("R7 read closed bank", 3'd5, 12'h010);
        cyc("R7 reserved code", 1, 0, 1, 1, 0, 3'd1, 12'h000);
        cyc("R7 ref while open", 1, 0, 0, 0, 1, 3'd0, 12'h000);
        mrs("R8 mrs while open", 3'd0, 12'h035);
        pre("R5 pre single idle", 3'd6, 1'b0);
        pre("R5 pre single bank3", 3'd3, 1'b0);
        act("R5 act bank1", 3'd1, 12'hFFF);
        act("R5 act bank2", 3'd2, 12'h800);
        pre("R5 pre all", 3'd7, 1'b1);
        cyc("R11 ref idle", 1, 0, 0, 0, 1, 3'd0, 12'h000);
        mrs("R8 mrs load", 3'd0, 12'h035);
        mrs("R8 mrs bad cl code", 3'd0, 12'h00E);
        mrs("R8 mrs bad wl code", 3'd0, 12'h070);
        mrs("R8 mrs other bank", 3'd1, 12'h07F);
        act("R6 act bank6", 3'd6, 12'h246);
        rd("R6 read ap bl8 cl9", 3'd6, 12'h100);
        nop("R6 read ap countdown", 15);
        act("R6 act bank7", 3'd7, 12'h777);
        wr("R6 write ap wl4", 3'd7, 12'h1C3);
        nop("R6 write ap countdown", 10);
        act("R5 act bank4", 3'd4, 12'h404);
        rd("R5 read ap bank4", 3'd4, 12'h100);
        nop("R5 wait", 2);
        pre("R5 pre cancels ap", 3'd4, 1'b0);
        nop("R5 after cancel", 2);
        cyc("R9 cke low idle", 0, 0, 0, 1, 1, 3'd2, 12'h321);
        cyc("R10 pdn act ignored", 0, 0, 0, 1, 1, 3'd2, 12'h321);
        cyc("R10 pdn exit", 1, 0, 0, 1, 1, 3'd2, 12'h321);
        nop("R10 run", 1);
        act("R9 act bank2", 3'd2, 12'h0F0);
        act("R9 act bank1", 3'd1, 12'h00F);
        wr("R10 write ap bank1", 3'd1, 12'h100);
        cyc("R9 cke low open", 0, 0, 1, 1, 1, 3'd0, 12'h000);
        for (int i = 0; i < 12; i++)
            cyc("R10 pdn countdown", 0, 0, 0, 1, 0, 3'd2, 12'h100);
        cyc("R10 pdn exit active", 1, 0, 0, 1, 0, 3'd2, 12'h100);
        rd("R4 read bank2", 3'd2, 12'h2FF);
        pre("R5 final pre all", 3'd0, 1'b1);
        nop("R1 tail", 3);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule